// File: doc/BRIEF.md
# Dual-Channel Disk Card Address Decoder

This block sits between a simple synchronous host bus and the two drive interfaces of a dual-channel parallel disk expansion card. It decodes each host access into a chip select and a register index for one channel's command block or control block. It also holds the card's one-byte select register and answers reads of the four board-type locations.

The select register has two jobs. Bit 5 opens the window through which the taskfile registers are reached. Bit 0 steers the DMA handshake to channel 0 or channel 1. Writing zero closes the window and clears the identity read pointer. Taskfile registers are spaced 64 bytes apart, so the register index is the address offset from the channel base shifted right by six. The board type is read one bit per location, at four consecutive word addresses.

The decode path is combinational. A chip select and the read data follow the host strobe within the same cycle. Only the select register and the pointer-clear pulse are clocked.

Top module: `xcd_addr_decode`

## Requirements
- R1: The select register (address 0x0000) resets to 0x00. A write stores all eight bits at the next clock edge, and a read at that address returns the stored byte. Writes to any other address leave it unchanged.
- R2: Output `window_en` follows select bit 5, and output `dma_chan` follows select bit 0.
- R3: A write of 0x00 to the select register raises `rom_ptr_clr` for exactly the one cycle after the write edge. A write of any nonzero value raises no pulse.
- R4: With the window open, an access (read or write) at channel base + (k << 6), with k in 0..7, asserts `cs_cmd[c]` and drives `reg_idx` = k during the strobe. The channel 0 base is 0x2000 and the channel 1 base is 0x3000.
- R5: With the window open, an access at 0x2380 (channel 0) or 0x3380 (channel 1) asserts `cs_ctl[c]` with `reg_idx` = 0. The same address serves control writes and alternate-status reads.
- R6: With the window closed, no chip select is asserted and a taskfile read returns 0xFF.
- R7: A read at 0x2280 + 4*n, with n in 0..3, returns bit n of the board type in data bit 0, with data bits 7:1 at zero. The board type is 3, and these reads work whether the window is open or closed.
- R8: An address in no decoded region gives no chip select, reads 0xFF, and a write there has no effect. This covers a taskfile offset that is not a multiple of 64, and offsets at or beyond 8 << 6 from a base.
- R9: A taskfile read returns `dev_rdata` in the same cycle. `dev_rd` and `dev_wr` repeat the host strobes only while a chip select is asserted.
- R10: While `bus_rd` is low, `bus_rdata` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 14 | Host byte address |
| bus_wdata | input | 8 | Host write data |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_rdata | output | 8 | Host read data |
| dev_rdata | input | 8 | Read data returned by the selected drive interface |
| cs_cmd | output | 2 | Per-channel command block chip select |
| cs_ctl | output | 2 | Per-channel control block chip select |
| reg_idx | output | 3 | Taskfile register index |
| dev_rd | output | 1 | Read strobe toward the drive interfaces |
| dev_wr | output | 1 | Write strobe toward the drive interfaces |
| window_en | output | 1 | Taskfile window open |
| dma_chan | output | 1 | Channel receiving the DMA handshake |
| rom_ptr_clr | output | 1 | One-cycle clear of the identity read pointer |

## Verification
A corrupted select register shows up one clock after the write that should have set it. It appears on `window_en` and `dma_chan`, on the byte read back at address 0x0000, and in whether taskfile accesses raise any chip select at all. A decode fault is combinational and appears in the same cycle as the strobe: a wrong or doubled chip select, a wrong `reg_idx`, or 0xFF where drive data was due. An identity fault appears as a wrong bit 0 on one of the four type reads. A missing or extra `rom_ptr_clr` shows in the cycle after a select write.

// File: rtl/xcd_pkg.sv
package xcd_pkg;

  localparam int unsigned ADDR_W = 14;
  localparam int unsigned DATA_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  // Offset of an address from a base. Only meaningful when the address is at or above the base.
  function automatic int unsigned span_offset(addr_t a, int unsigned base);
    return 32'(a) - base;
  endfunction

  // True when the address falls on one of nreg registers spaced (1 << step) apart from base.
  function automatic logic stepped_hit(addr_t a, int unsigned base,
                                       int unsigned step, int unsigned nreg);
    int unsigned off;
    off = span_offset(a, base);
    return (32'(a) >= base) && (off < (nreg << step)) &&
           ((off & ((32'd1 << step) - 32'd1)) == 32'd0);
  endfunction

  // Register number addressed inside a stepped block.
  function automatic int unsigned stepped_index(addr_t a, int unsigned base, int unsigned step);
    return span_offset(a, base) >> step;
  endfunction

  // Address of identity bit n.
  function automatic int unsigned id_slot_addr(int unsigned idbase, int unsigned shift,
                                               int unsigned n);
    return idbase + (n << shift);
  endfunction

endpackage

// File: rtl/xcd_selreg.sv
module xcd_selreg
  import xcd_pkg::*;
#(
  parameter int unsigned SEL_ADDR = 32'h0000,
  parameter int unsigned WIN_BIT  = 5,
  parameter int unsigned CHAN_BIT = 0,
  parameter int unsigned CSEL_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  addr_t             addr,
  input  logic              wr_en,
  input  byte_t             wdata,
  output byte_t             sel_q,
  output logic              sel_hit,
  output logic              sel_wr_evt,
  output logic              window_en,
  output logic [CSEL_W-1:0] dma_chan,
  output logic              rom_ptr_clr
);

  assign sel_hit    = (32'(addr) == SEL_ADDR);
  assign sel_wr_evt = wr_en && sel_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q       <= '0;
      rom_ptr_clr <= 1'b0;
    end else begin
      if (sel_wr_evt) sel_q <= wdata;
      rom_ptr_clr <= sel_wr_evt && (wdata == '0);
    end
  end

  assign window_en = sel_q[WIN_BIT];
  assign dma_chan  = sel_q[CHAN_BIT +: CSEL_W];

endmodule

// File: rtl/xcd_chan_dec.sv
module xcd_chan_dec
  import xcd_pkg::*;
#(
  parameter int unsigned CMD_BASE = 32'h2000,
  parameter int unsigned CTL_ADDR = 32'h2380,
  parameter int unsigned STEP     = 6,
  parameter int unsigned NREG     = 8,
  parameter int unsigned IDX_W    = 3
) (
  input  addr_t            addr,
  input  logic             strobe,
  input  logic             window_en,
  output logic             cs_cmd,
  output logic             cs_ctl,
  output logic [IDX_W-1:0] idx
);

  logic cmd_match;
  logic ctl_match;
  logic [IDX_W-1:0] raw_idx;

  always_comb begin
    cmd_match = stepped_hit(addr, CMD_BASE, STEP, NREG);
    ctl_match = (32'(addr) == CTL_ADDR);
    raw_idx   = IDX_W'(stepped_index(addr, CMD_BASE, STEP));
  end

  assign cs_cmd = strobe && window_en && cmd_match;
  assign cs_ctl = strobe && window_en && ctl_match;
  assign idx    = cs_cmd ? raw_idx : '0;

endmodule

// File: rtl/xcd_id_dec.sv
module xcd_id_dec
  import xcd_pkg::*;
#(
  parameter int unsigned ID_BASE  = 32'h2280,
  parameter int unsigned ID_SHIFT = 2,
  parameter int unsigned ID_BITS  = 4,
  parameter logic [ID_BITS-1:0] BOARD_ID = 4'd3
) (
  input  addr_t addr,
  output logic  id_hit,
  output byte_t id_byte
);

  logic [ID_BITS-1:0] slot_hit;

  for (genvar n = 0; n < ID_BITS; n++) begin : g_slot
    assign slot_hit[n] = (32'(addr) == id_slot_addr(ID_BASE, ID_SHIFT, n));
  end

  assign id_hit  = |slot_hit;
  assign id_byte = {{(DATA_W-1){1'b0}}, |(slot_hit & BOARD_ID)};

endmodule

// File: rtl/xcd_addr_decode.sv
module xcd_addr_decode
  import xcd_pkg::*;
#(
  parameter int unsigned NCHAN       = 2,
  parameter int unsigned SEL_ADDR    = 32'h0000,
  parameter int unsigned WIN_BIT     = 5,
  parameter int unsigned CHAN_BIT    = 0,
  parameter int unsigned CMD_BASE0   = 32'h2000,
  parameter int unsigned CHAN_STRIDE = 32'h1000,
  parameter int unsigned CTL_OFF     = 32'h0380,
  parameter int unsigned REG_STEP    = 6,
  parameter int unsigned NREG        = 8,
  parameter int unsigned ID_BASE     = 32'h2280,
  parameter int unsigned ID_SHIFT    = 2,
  parameter int unsigned ID_BITS     = 4,
  parameter logic [ID_BITS-1:0] BOARD_ID = 4'd3,
  localparam int unsigned IDX_W  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int unsigned CSEL_W = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [13:0]       bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        dev_rdata,
  output logic [NCHAN-1:0]  cs_cmd,
  output logic [NCHAN-1:0]  cs_ctl,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              dev_rd,
  output logic              dev_wr,
  output logic              window_en,
  output logic [CSEL_W-1:0] dma_chan,
  output logic              rom_ptr_clr
);

  // Named internal events, also observed by the bound checker.
  byte_t sel_q;
  logic  sel_hit;
  logic  sel_wr_evt;
  logic  id_hit;
  byte_t id_byte;
  logic  access;
  logic  tf_sel;
  logic [IDX_W-1:0] ch_idx [NCHAN];

  assign access = bus_rd || bus_wr;

  xcd_selreg #(
    .SEL_ADDR(SEL_ADDR), .WIN_BIT(WIN_BIT), .CHAN_BIT(CHAN_BIT), .CSEL_W(CSEL_W)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr), .wdata(bus_wdata),
    .sel_q(sel_q), .sel_hit(sel_hit), .sel_wr_evt(sel_wr_evt),
    .window_en(window_en), .dma_chan(dma_chan), .rom_ptr_clr(rom_ptr_clr)
  );

  for (genvar c = 0; c < NCHAN; c++) begin : g_ch
    xcd_chan_dec #(
      .CMD_BASE(CMD_BASE0 + c * CHAN_STRIDE),
      .CTL_ADDR(CMD_BASE0 + c * CHAN_STRIDE + CTL_OFF),
      .STEP(REG_STEP), .NREG(NREG), .IDX_W(IDX_W)
    ) u_dec (
      .addr(bus_addr), .strobe(access), .window_en(window_en),
      .cs_cmd(cs_cmd[c]), .cs_ctl(cs_ctl[c]), .idx(ch_idx[c])
    );
  end

  xcd_id_dec #(
    .ID_BASE(ID_BASE), .ID_SHIFT(ID_SHIFT), .ID_BITS(ID_BITS), .BOARD_ID(BOARD_ID)
  ) u_id (
    .addr(bus_addr), .id_hit(id_hit), .id_byte(id_byte)
  );

  always_comb begin
    reg_idx = '0;
    for (int c = 0; c < NCHAN; c++) reg_idx |= ch_idx[c];
  end

  assign tf_sel = |{cs_cmd, cs_ctl};
  assign dev_rd = bus_rd && tf_sel;
  assign dev_wr = bus_wr && tf_sel;

  always_comb begin
    bus_rdata = '1;
    if (bus_rd) begin
      if (sel_hit)     bus_rdata = sel_q;
      else if (id_hit) bus_rdata = id_byte;
      else if (tf_sel) bus_rdata = dev_rdata;
    end
  end

endmodule

// File: rtl/xcd_addr_decode_chk.sv
module xcd_addr_decode_chk #(
  parameter int unsigned NCHAN   = 2,
  parameter int unsigned WIN_BIT = 5,
  parameter int unsigned CSEL_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        bus_wdata,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic [NCHAN-1:0]  cs_cmd,
  input logic [NCHAN-1:0]  cs_ctl,
  input logic              window_en,
  input logic [CSEL_W-1:0] dma_chan,
  input logic              rom_ptr_clr,
  input logic              sel_hit,
  input logic              sel_wr_evt,
  input logic              id_hit
);

  p_sel_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr_evt |=> ($stable(window_en) && $stable(dma_chan)));

  p_win_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr_evt |=> (window_en == $past(bus_wdata[WIN_BIT])));

  p_clr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr_evt && bus_wdata == 8'h00) |=> rom_ptr_clr);

  p_clr_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rom_ptr_clr |-> ($past(sel_wr_evt) && $past(bus_wdata) == 8'h00));

  p_one_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_cmd, cs_ctl}));

  p_closed_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !window_en |-> ({cs_cmd, cs_ctl} == '0));

  p_miss_reads_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !sel_hit && !id_hit && ({cs_cmd, cs_ctl} == '0)) |-> (bus_rdata == 8'hFF));

  p_idle_ff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'hFF));

endmodule

bind xcd_addr_decode xcd_addr_decode_chk #(
  .NCHAN(NCHAN), .WIN_BIT(WIN_BIT), .CSEL_W(CSEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .cs_cmd(cs_cmd), .cs_ctl(cs_ctl), .window_en(window_en),
  .dma_chan(dma_chan), .rom_ptr_clr(rom_ptr_clr), .sel_hit(sel_hit),
  .sel_wr_evt(sel_wr_evt), .id_hit(id_hit)
);

// File: tb/xcd_addr_decode_test.sv
`timescale 1ns/1ps
module xcd_addr_decode_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] dev_rdata = '0;
  logic [1:0] cs_cmd, cs_ctl;
  logic [2:0] reg_idx;
  logic       dev_rd, dev_wr, window_en, dma_chan, rom_ptr_clr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xcd_addr_decode uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .dev_rdata(dev_rdata),
    .cs_cmd(cs_cmd), .cs_ctl(cs_ctl), .reg_idx(reg_idx), .dev_rd(dev_rd),
    .dev_wr(dev_wr), .window_en(window_en), .dma_chan(dma_chan), .rom_ptr_clr(rom_ptr_clr)
  );

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic [13:0] a;
    logic [7:0]  dd;
    logic [7:0]  er;
    logic [1:0]  ec;
    logic [1:0]  et;
    logic [2:0]  ei;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 15;
  // Walked with the window open and select = 0x21.
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 14'h2000, 8'h5A, 8'h5A, 2'b01, 2'b00, 3'd0, 4'd4}, // R4 ch0 reg0 read
    '{1'b1, 1'b0, 14'h21C0, 8'h33, 8'h33, 2'b01, 2'b00, 3'd7, 4'd4}, // R4 ch0 last reg
    '{1'b0, 1'b1, 14'h2080, 8'h00, 8'hFF, 2'b01, 2'b00, 3'd2, 4'd4}, // R4 ch0 write reg2
    '{1'b1, 1'b0, 14'h3040, 8'hC3, 8'hC3, 2'b10, 2'b00, 3'd1, 4'd4}, // R4 ch1 reg1
    '{1'b0, 1'b1, 14'h31C0, 8'h00, 8'hFF, 2'b10, 2'b00, 3'd7, 4'd4}, // R4 ch1 write reg7
    '{1'b1, 1'b0, 14'h2380, 8'h77, 8'h77, 2'b00, 2'b01, 3'd0, 4'd5}, // R5 ch0 alt status
    '{1'b0, 1'b1, 14'h3380, 8'h00, 8'hFF, 2'b00, 2'b10, 3'd0, 4'd5}, // R5 ch1 control write
    '{1'b1, 1'b0, 14'h2004, 8'h11, 8'hFF, 2'b00, 2'b00, 3'd0, 4'd8}, // R8 misaligned
    '{1'b1, 1'b0, 14'h2200, 8'h11, 8'hFF, 2'b00, 2'b00, 3'd0, 4'd8}, // R8 past reg7
    '{1'b1, 1'b0, 14'h2280, 8'h99, 8'h01, 2'b00, 2'b00, 3'd0, 4'd7}, // R7 id bit0
    '{1'b1, 1'b0, 14'h2284, 8'h99, 8'h01, 2'b00, 2'b00, 3'd0, 4'd7}, // R7 id bit1
    '{1'b1, 1'b0, 14'h2288, 8'h99, 8'h00, 2'b00, 2'b00, 3'd0, 4'd7}, // R7 id bit2
    '{1'b1, 1'b0, 14'h228C, 8'h99, 8'h00, 2'b00, 2'b00, 3'd0, 4'd7}, // R7 id bit3
    '{1'b1, 1'b0, 14'h1234, 8'h44, 8'hFF, 2'b00, 2'b00, 3'd0, 4'd8}, // R8 unmapped
    '{1'b1, 1'b0, 14'h0000, 8'h44, 8'h21, 2'b00, 2'b00, 3'd0, 4'd1}  // R1 readback
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic rd, input logic wr, input logic [13:0] a,
                     input logic [7:0] wd, input logic [7:0] dd);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; dev_rdata = dd;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr_sel(input logic [7:0] v);
    put(1'b0, 1'b1, 14'h0000, v, 8'h00);
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 / R2 / R3 / R10 reset state
    chk("R2 window after reset", 16'(window_en), 16'h0);
    chk("R2 dma_chan after reset", 16'(dma_chan), 16'h0);
    chk("R3 no clear pulse after reset", 16'(rom_ptr_clr), 16'h0);
    chk("R10 idle read data", 16'(bus_rdata), 16'hFF);
    put(1'b1, 1'b0, 14'h0000, 8'h00, 8'h00); #2;
    chk("R1 reset readback", 16'(bus_rdata), 16'h00);

    // R6 window closed: no selects, taskfile read is 0xFF
    put(1'b1, 1'b0, 14'h2000, 8'h00, 8'hA5); #2;
    chk("R6 closed read data", 16'(bus_rdata), 16'hFF);
    chk("R6 closed selects", 16'({cs_cmd, cs_ctl}), 16'h0);
    chk("R6 closed dev_rd", 16'(dev_rd), 16'h0);
    put(1'b0, 1'b1, 14'h3380, 8'h12, 8'h00); #2;
    chk("R6 closed ctl write selects", 16'({cs_cmd, cs_ctl, dev_wr}), 16'h0);
    // R7 identity readable while closed
    put(1'b1, 1'b0, 14'h2284, 8'h00, 8'h00); #2;
    chk("R7 id bit1 while closed", 16'(bus_rdata), 16'h01);
    idle();

    // R2 / R3 open window, steer DMA to channel 1
    wr_sel(8'h21);
    chk("R2 window opened", 16'(window_en), 16'h1);
    chk("R2 dma to channel 1", 16'(dma_chan), 16'h1);
    chk("R3 no pulse on nonzero write", 16'(rom_ptr_clr), 16'h0);
    idle();

    // Table walk: R4 R5 R7 R8 R9 R1
    for (int i = 0; i < NV; i++) begin
      put(TBL[i].rd, TBL[i].wr, TBL[i].a, 8'h00, TBL[i].dd); #2;
      chk($sformatf("R%0d vec %0d rdata", TBL[i].rq, i), 16'(bus_rdata), 16'(TBL[i].er));
      chk($sformatf("R%0d vec %0d cs_cmd", TBL[i].rq, i), 16'(cs_cmd), 16'(TBL[i].ec));
      chk($sformatf("R%0d vec %0d cs_ctl", TBL[i].rq, i), 16'(cs_ctl), 16'(TBL[i].et));
      chk($sformatf("R%0d vec %0d reg_idx", TBL[i].rq, i), 16'(reg_idx), 16'(TBL[i].ei));
      // R9 drive strobes only with a select
      chk($sformatf("R9 vec %0d dev_rd", i), 16'(dev_rd),
          16'(TBL[i].rd && (TBL[i].ec != 0 || TBL[i].et != 0)));
      chk($sformatf("R9 vec %0d dev_wr", i), 16'(dev_wr),
          16'(TBL[i].wr && (TBL[i].ec != 0 || TBL[i].et != 0)));
    end
    idle(); #2;
    chk("R10 idle after walk", 16'(bus_rdata), 16'hFF);

    // R8 write to unmapped address leaves select untouched, no pulse
    put(1'b0, 1'b1, 14'h0004, 8'h00, 8'h00);
    @(posedge clk); #1;
    chk("R8 unmapped write no pulse", 16'(rom_ptr_clr), 16'h0);
    idle();
    put(1'b1, 1'b0, 14'h0000, 8'h00, 8'h00); #2;
    chk("R8 select unchanged", 16'(bus_rdata), 16'h21);
    idle();

    // R2 steer back to channel 0, window stays open
    wr_sel(8'h20);
    chk("R2 dma to channel 0", 16'(dma_chan), 16'h0);
    chk("R2 window still open", 16'(window_en), 16'h1);
    idle();

    // R3 zero write: one-cycle pulse, window closes
    wr_sel(8'h00);
    chk("R3 clear pulse high", 16'(rom_ptr_clr), 16'h1);
    chk("R2 window closed by zero", 16'(window_en), 16'h0);
    idle();
    @(posedge clk); #1;
    chk("R3 clear pulse one cycle", 16'(rom_ptr_clr), 16'h0);
    put(1'b1, 1'b0, 14'h3000, 8'h00, 8'h66); #2;
    chk("R6 closed again", 16'({bus_rdata, 6'b0, cs_cmd}), 16'hFF00);
    idle();

    done = 1'b1;
    summary();
  end

endmodule